// File: doc/BRIEF.md
# Four-Mode BIST Observation Register

This block is an n-bit register that shares one set of flip-flops across four roles, chosen by two mode pins. As a plain register it passes upstream parallel data to the downstream logic one cycle later. As a scan chain it shifts one bit per cycle from the serial input toward the last stage. As an autonomous pattern generator it steps a linear feedback shift register whose state drives stimulus into a circuit under test. As a multiple-input signature register it folds that circuit's parallel responses into a running signature.

The feedback taps are a parameter. The default puts a tap on every stage, which is the polynomial with every term from 1 to x^n. The register has no reset or clear input. It is zeroed by shifting zeros in through scan, and a non-zero seed for generation is loaded the same way. A low enable freezes the register in every mode.

Top module: `bist_obs_reg`

## Requirements
- R1: With mode code {mode_hi, mode_lo} = 2'b10 and en high, pdata_out equals the pdata_in value present at the previous rising clock edge.
- R2: With mode code 2'b00 and en high, every stage takes the value of the stage below it and stage 0 takes scan_in, so the next state is {state[WIDTH-2:0], scan_in}.
- R3: With mode code 2'b01 and en high, the next state is {state[WIDTH-2:0], fb}, where fb is the XOR of all stages i with TAPS[i] set. pdata_in has no effect on the state.
- R4: With mode code 2'b11 and en high, the next state is {state[WIDTH-2:0], fb} XOR pdata_in, with fb as in R3.
- R5: With en low the state does not change, whatever the mode and data inputs are.
- R6: scan_out always equals the last stage, state[WIDTH-1], in every mode.
- R7: Shifting WIDTH zeros in through scan mode leaves every stage at zero, from any starting state.
- R8: With a primitive tap set (TAPS = 8'hB8 for WIDTH 8) and a non-zero seed, generation mode returns to the seed after exactly 2^WIDTH-1 steps and never reaches the all-zero state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every stage updates on its rising edge |
| en | input | 1 | Update enable; when low the state holds |
| mode_hi | input | 1 | Upper mode bit |
| mode_lo | input | 1 | Lower mode bit |
| scan_in | input | 1 | Serial data into stage 0 in scan mode |
| pdata_in | input | WIDTH | Parallel data from upstream logic or circuit responses |
| pdata_out | output | WIDTH | Register state toward downstream logic or circuit under test |
| scan_out | output | 1 | Last stage of the register |

## Verification
The bench drives every value of the 8-bit parallel input in both load mode and signature mode, so an inverted, swapped or dropped XOR term in the signature path shows as a wrong word. Generation steps run while pdata_in keeps changing, so a design that leaks data into the generator drifts from the model. The full cycle of a primitive tap set is walked to its end, so a wrong tap or a wrong shift direction gives the wrong period or hits the all-zero lockup state. Clearing by scan and holding with en low are checked in all four modes, so a stage that ignores the enable, or a chain broken at any point, leaves a wrong bit behind.

// File: rtl/bist_obs_pkg.sv
package bist_obs_pkg;

   typedef enum logic [1:0] {
      MODE_SCAN = 2'b00,
      MODE_GEN  = 2'b01,
      MODE_LOAD = 2'b10,
      MODE_SIG  = 2'b11
   } bist_mode_e;

   typedef struct packed {
      logic shift;
      logic load;
      logic sig;
      logic head_scan;
   } stage_ctl_t;

endpackage

// File: rtl/bist_obs_mode_dec.sv
module bist_obs_mode_dec
   import bist_obs_pkg::*;
(
   input  logic       mode_hi,
   input  logic       mode_lo,
   output stage_ctl_t ctl
);

   bist_mode_e mode;

   assign mode = bist_mode_e'({mode_hi, mode_lo});

   always_comb begin
      ctl = '0;
      unique case (mode)
         MODE_SCAN: begin
            ctl.shift     = 1'b1;
            ctl.head_scan = 1'b1;
         end
         MODE_GEN:  ctl.shift = 1'b1;
         MODE_LOAD: ctl.load  = 1'b1;
         MODE_SIG:  ctl.sig   = 1'b1;
         default:   ctl       = '0;
      endcase
   end

endmodule

// File: rtl/bist_obs_feedback.sv
module bist_obs_feedback #(
   parameter int unsigned      WIDTH = 8,
   parameter logic [WIDTH-1:0] TAPS  = {WIDTH{1'b1}}
) (
   input  logic [WIDTH-1:0] state,
   output logic             fb
);

   logic [WIDTH-1:0] term;

   for (genvar i = 0; i < WIDTH; i++) begin : g_tap
      if (TAPS[i]) begin : g_on
         assign term[i] = state[i];
      end else begin : g_off
         assign term[i] = 1'b0;
      end
   end

   assign fb = ^term;

endmodule

// File: rtl/bist_obs_stage.sv
module bist_obs_stage
   import bist_obs_pkg::*;
(
   input  logic       clk,
   input  logic       en,
   input  stage_ctl_t ctl,
   input  logic       prev,
   input  logic       din,
   output logic       q
);

   logic nxt;

   always_comb begin
      nxt = q;
      if (ctl.shift)     nxt = prev;
      else if (ctl.load) nxt = din;
      else if (ctl.sig)  nxt = prev ^ din;
   end

   always_ff @(posedge clk) begin
      if (en) q <= nxt;
   end

   logic unused_ctl;
   assign unused_ctl = ctl.head_scan;

endmodule

// File: rtl/bist_obs_reg.sv
module bist_obs_reg
   import bist_obs_pkg::*;
#(
   parameter int unsigned      WIDTH = 8,
   parameter logic [WIDTH-1:0] TAPS  = {WIDTH{1'b1}}
) (
   input  logic             clk,
   input  logic             en,
   input  logic             mode_hi,
   input  logic             mode_lo,
   input  logic             scan_in,
   input  logic [WIDTH-1:0] pdata_in,
   output logic [WIDTH-1:0] pdata_out,
   output logic             scan_out
);

   localparam int unsigned LAST = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("bist_obs_reg: WIDTH must be at least 2");
   end
   if (!TAPS[LAST]) begin : g_bad_taps
      $error("bist_obs_reg: TAPS must include the last stage");
   end

   stage_ctl_t       ctl;
   logic             fb;
   logic             head;
   logic [WIDTH-1:0] state;
   logic [WIDTH-1:0] prev;

   bist_obs_mode_dec u_dec (
      .mode_hi (mode_hi),
      .mode_lo (mode_lo),
      .ctl     (ctl)
   );

   bist_obs_feedback #(
      .WIDTH (WIDTH),
      .TAPS  (TAPS)
   ) u_fb (
      .state (state),
      .fb    (fb)
   );

   assign head = ctl.head_scan ? scan_in : fb;

   for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      if (i == 0) begin : g_head
         assign prev[i] = head;
      end else begin : g_body
         assign prev[i] = state[i-1];
      end

      bist_obs_stage u_stage (
         .clk  (clk),
         .en   (en),
         .ctl  (ctl),
         .prev (prev[i]),
         .din  (pdata_in[i]),
         .q    (state[i])
      );
   end

   assign pdata_out = state;
   assign scan_out  = state[LAST];

endmodule

// File: rtl/bist_obs_reg_chk.sv
module bist_obs_reg_chk #(
   parameter int unsigned      WIDTH = 8,
   parameter logic [WIDTH-1:0] TAPS  = {WIDTH{1'b1}}
) (
   input logic             clk,
   input logic             en,
   input logic             mode_hi,
   input logic             mode_lo,
   input logic             scan_in,
   input logic [WIDTH-1:0] pdata_in,
   input logic [WIDTH-1:0] pdata_out,
   input logic             scan_out
);

   logic primed = 1'b0;
   always_ff @(posedge clk) primed <= 1'b1;

   logic [1:0] md;
   assign md = {mode_hi, mode_lo};

   assert_scan_shift_R2: assert property (@(posedge clk) disable iff (!primed)
      (en && md == 2'b00) |=> pdata_out == {$past(pdata_out[WIDTH-2:0]), $past(scan_in)});

   assert_gen_step_R3: assert property (@(posedge clk) disable iff (!primed)
      (en && md == 2'b01) |=>
         pdata_out == {$past(pdata_out[WIDTH-2:0]), ^($past(pdata_out) & TAPS)});

   assert_load_R1: assert property (@(posedge clk) disable iff (!primed)
      (en && md == 2'b10) |=> pdata_out == $past(pdata_in));

   assert_sig_fold_R4: assert property (@(posedge clk) disable iff (!primed)
      (en && md == 2'b11) |=>
         pdata_out == ({$past(pdata_out[WIDTH-2:0]), ^($past(pdata_out) & TAPS)} ^ $past(pdata_in)));

   assert_hold_R5: assert property (@(posedge clk) disable iff (!primed)
      !en |=> $stable(pdata_out));

   assert_tail_R6: assert property (@(posedge clk) disable iff (!primed)
      en |=> scan_out == $past(pdata_out[WIDTH-2]) ^ ($past(md) == 2'b10 ? $past(pdata_in[WIDTH-1]) ^ $past(pdata_out[WIDTH-2]) :
                                                      $past(md) == 2'b11 ? $past(pdata_in[WIDTH-1]) : 1'b0));

endmodule

bind bist_obs_reg bist_obs_reg_chk #(
   .WIDTH (WIDTH),
   .TAPS  (TAPS)
) u_chk (
   .clk       (clk),
   .en        (en),
   .mode_hi   (mode_hi),
   .mode_lo   (mode_lo),
   .scan_in   (scan_in),
   .pdata_in  (pdata_in),
   .pdata_out (pdata_out),
   .scan_out  (scan_out)
);

// File: tb/bist_obs_reg_bench.sv
module bist_obs_reg_bench;

   localparam int W = 8;
   localparam logic [W-1:0] PRIM = 8'hB8;
   localparam logic [W-1:0] ALL  = 8'hFF;

   logic         clk = 1'b0;
   logic         en = 1'b0;
   logic         mode_hi = 1'b0;
   logic         mode_lo = 1'b0;
   logic         scan_in = 1'b0;
   logic [W-1:0] pdata_in = '0;
   logic [W-1:0] out_a, out_b;
   logic         so_a, so_b;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 1'b0;
   bit track  = 1'b0;
   logic [W-1:0] m_a = '0;
   logic [W-1:0] m_b = '0;

   always #5 clk = ~clk;

   bist_obs_reg #(.WIDTH(W), .TAPS(ALL)) u_bist_obs_reg (
      .clk(clk), .en(en), .mode_hi(mode_hi), .mode_lo(mode_lo),
      .scan_in(scan_in), .pdata_in(pdata_in), .pdata_out(out_a), .scan_out(so_a));

   bist_obs_reg #(.WIDTH(W), .TAPS(PRIM)) u_bist_obs_reg_prim (
      .clk(clk), .en(en), .mode_hi(mode_hi), .mode_lo(mode_lo),
      .scan_in(scan_in), .pdata_in(pdata_in), .pdata_out(out_b), .scan_out(so_b));

   function automatic logic [W-1:0] model(input logic [W-1:0] q, input logic [W-1:0] taps,
                                          input logic e, input logic [1:0] md,
                                          input logic si, input logic [W-1:0] d);
      logic fb;
      fb = ^(q & taps);
      if (!e) return q;
      case (md)
         2'b00:   return {q[W-2:0], si};
         2'b01:   return {q[W-2:0], fb};
         2'b10:   return d;
         default: return {q[W-2:0], fb} ^ d;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic string tag_of(input logic e, input logic [1:0] md);
      if (!e) return "R5 hold";
      case (md)
         2'b00:   return "R2 scan";
         2'b01:   return "R3 gen";
         2'b10:   return "R1 load";
         default: return "R4 sig";
      endcase
   endfunction

   task automatic step(input logic e, input logic [1:0] md, input logic si, input logic [W-1:0] d);
      en = e; mode_hi = md[1]; mode_lo = md[0]; scan_in = si; pdata_in = d;
      @(posedge clk); #1;
      m_a = model(m_a, ALL, e, md, si, d);
      m_b = model(m_b, PRIM, e, md, si, d);
      if (track) begin
         chk(tag_of(e, md), out_a, m_a);
         chk(tag_of(e, md), out_b, m_b);
         chk("R6 scan_out", {7'd0, so_a}, {7'd0, m_a[W-1]});
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected<150000", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int period;
      bit hit_zero;
      #2;
      // R7: load junk, then clear by shifting zeros
      step(1'b1, 2'b10, 1'b0, 8'hC7);
      track = 1'b1;
      m_a = out_a; m_b = out_b;
      for (int i = 0; i < W; i++) step(1'b1, 2'b00, 1'b0, 8'hFF);
      chk("R7 clear a", out_a, 8'h00);
      chk("R7 clear b", out_b, 8'h00);
      chk("R7 scan_out", {7'd0, so_a}, 8'h00);

      // R2 and R6: shift two patterns through the chain
      for (int i = 0; i < 16; i++) step(1'b1, 2'b00, logic'((16'hA53C >> i) & 1), 8'h5A);

      // R1: every parallel input value
      for (int v = 0; v < 256; v++) step(1'b1, 2'b10, 1'b1, W'(v));

      // R5: hold in all four modes with toggling inputs
      for (int md = 0; md < 4; md++) begin
         logic [W-1:0] a0;
         a0 = out_a;
         for (int k = 0; k < 3; k++) step(1'b0, 2'(md), logic'(k & 1), W'(8'h33 * (k + md + 1)));
         chk("R5 hold no change", out_a, a0);
      end

      // R3: seed by scan, then generate while pdata_in keeps moving
      for (int i = 0; i < W; i++) step(1'b1, 2'b00, logic'(i == W - 1), 8'h00);
      chk("R3 seed", out_a, 8'h01);
      for (int i = 0; i < 40; i++) step(1'b1, 2'b01, 1'b0, W'(i * 37));

      // R4: fold every possible response word from a cleared register
      for (int i = 0; i < W; i++) step(1'b1, 2'b00, 1'b0, 8'h00);
      for (int v = 0; v < 256; v++) step(1'b1, 2'b11, 1'b0, W'(v * 29 + 3));

      // R8: primitive taps, seed 0x01, walk the full cycle
      for (int i = 0; i < W; i++) step(1'b1, 2'b00, logic'(i == W - 1), 8'h00);
      chk("R8 seed", out_b, 8'h01);
      period = 0;
      hit_zero = 1'b0;
      for (int i = 1; i <= 300; i++) begin
         step(1'b1, 2'b01, 1'b0, W'(i));
         if (out_b == 8'h00) hit_zero = 1'b1;
         if (out_b == 8'h01 && period == 0) period = i;
      end
      chk("R8 period", W'(period), W'(255));
      chk("R8 never zero", {7'd0, hit_zero}, 8'h00);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule